// File: doc/BRIEF.md
# Seconds-to-Weekday Timekeeper with Alarm

This block keeps time of day (seconds, minutes, hours) and a day-of-week number, and raises an interrupt when the running time meets an alarm set-point. A prescaler counts either crystal ticks or mains-derived pulses and emits a one-cycle "second" enable. That enable advances a chain of wrapping counters. The same enable also starts an alarm comparison in the following cycle. Both tick inputs are single-cycle enables that are already synchronous to `clk`.

Software reaches every register through a simple synchronous bus. Reads are combinational on `bus_rdata`, and a read or write takes effect at the rising edge where `bus_sel` is high. The register map uses these byte addresses:

- 0: control register.
- 1 to 4: seconds, minutes, hours and day-of-week counts.
- 5 to 8: the matching alarm set-points.
- 9: the alarm enable mask.

The control register has these fields:

- bit 0 `hold`: 1 stops time and opens the count registers for writing.
- bit 1 `src_mains`: 1 selects the mains input, 0 selects the crystal input.
- bit 2 `mains60`: 1 selects 60 Hz, 0 selects 50 Hz.
- bit 3 `irq_en`: interrupt enable.
- bit 7 `alm_flag`: read-only alarm flag.

Bits 0 to 3 of the enable mask gate the seconds, minutes, hours and day-of-week fields of the alarm, in that order.

The prescaler is a two-state machine. It sits in HOLD while `hold`=1 and resets its count there. It moves HOLD→RUN (transition *release*) once `hold` reads 0, and RUN→HOLD (transition *freeze*) when `hold` reads 1. Any control write also restarts its count (transition *restart*, RUN→RUN).

Top module: `rtc_top`

## Requirements
- R1: After reset the control register reads 0x00, the enable mask reads 0x00, and the time reads 00:00:00 with day-of-week 1.
- R2: In RUN the prescaler gives one second per XTAL_DIV crystal ticks (default 32768) when `src_mains`=0. With `src_mains`=1 it gives one second per 50 mains pulses, or per 60 when `mains60`=1. Pulses on the unselected input have no effect.
- R3: No second elapses while `hold`=1. Every control write restarts the prescaler count from zero.
- R4: Count registers (addresses 1 to 4) accept writes only while `hold`=1. Writes while `hold`=0 are ignored.
- R5: Seconds and minutes wrap 59→0 and hours wrap 23→0, each carrying into the next field. Day-of-week wraps 7→1.
- R6: Alarm set-points (addresses 5 to 8) and the enable mask (address 9) can be written at any time and read back.
- R7: An alarm comparison matches only when every enabled field equals its count. Disabled fields are ignored, and an all-zero mask never matches.
- R8: A comparison is made in the cycle after each second increment, and a match sets `alm_flag`.
- R9: A control write with bit 0 = 0 forces a comparison in the next cycle, whatever `hold` was before.
- R10: `irq` is high exactly while both `alm_flag` and `irq_en` are 1.
- R11: A control read returns `alm_flag` in bit 7 and clears it, which also drops `irq`. A flag set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | One-cycle pulse per crystal period |
| mains_tick | input | 1 | One-cycle pulse per mains cycle |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with XTAL_DIV=4, so a crystal second costs four cycles. At that rate, full carries from 23:59:58 day 7 and several alarm seconds fit within a short run. The mains divisors stay at 50 and 60, and they are exercised with exact pulse counts one short of and equal to the divisor. The prescaler restart is checked by splitting a second around a control write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int AW = 4;
    localparam int DW = 8;

    localparam logic [AW-1:0] A_CTRL  = 4'd0;
    localparam logic [AW-1:0] A_SEC   = 4'd1;
    localparam logic [AW-1:0] A_MIN   = 4'd2;
    localparam logic [AW-1:0] A_HR    = 4'd3;
    localparam logic [AW-1:0] A_DOW   = 4'd4;
    localparam logic [AW-1:0] A_ASEC  = 4'd5;
    localparam logic [AW-1:0] A_AMIN  = 4'd6;
    localparam logic [AW-1:0] A_AHR   = 4'd7;
    localparam logic [AW-1:0] A_ADOW  = 4'd8;
    localparam logic [AW-1:0] A_AEN   = 4'd9;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } pre_state_t;

    typedef struct packed {
        logic [2:0] dow;
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int XTAL_DIV = 32768,
    parameter int M50_DIV  = 50,
    parameter int M60_DIV  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic mains_tick,
    input  logic src_mains,
    input  logic mains60,
    input  logic hold,
    input  logic restart,
    output logic sec_en
);
    localparam int MAXDIV = (XTAL_DIV > M60_DIV) ? XTAL_DIV : M60_DIV;
    localparam int CW     = $clog2(MAXDIV) + 1;

    pre_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          tick;

    assign tick = src_mains ? mains_tick : xtal_tick;
    assign last = src_mains ? (mains60 ? CW'(M60_DIV - 1) : CW'(M50_DIV - 1))
                            : CW'(XTAL_DIV - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (!hold) state_d = ST_RUN;
            ST_RUN:  if (hold)  state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || state_q == ST_HOLD || hold)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
    end

    always_comb begin
        sec_en = 1'b0;
        unique case (state_q)
            ST_HOLD: sec_en = 1'b0;
            ST_RUN:  sec_en = tick && !hold && !restart && (cnt_q == last);
        endcase
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && !restart && !hold && cnt_q < last)
            |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_restart_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sec_en);
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_en,
    input  logic       hold,
    input  logic [3:0] wr_field,
    input  logic [7:0] wdata,
    output tod_t       tod
);
    tod_t t_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.sec <= '0;
            t_q.min <= '0;
            t_q.hr  <= '0;
            t_q.dow <= 3'd1;
        end else if (hold) begin
            if (wr_field[0]) t_q.sec <= wdata[5:0];
            if (wr_field[1]) t_q.min <= wdata[5:0];
            if (wr_field[2]) t_q.hr  <= wdata[4:0];
            if (wr_field[3]) t_q.dow <= wdata[2:0];
        end else if (sec_en) begin
            if (t_q.sec != 6'd59) begin
                t_q.sec <= t_q.sec + 1'b1;
            end else begin
                t_q.sec <= '0;
                if (t_q.min != 6'd59) begin
                    t_q.min <= t_q.min + 1'b1;
                end else begin
                    t_q.min <= '0;
                    if (t_q.hr != 5'd23) begin
                        t_q.hr <= t_q.hr + 1'b1;
                    end else begin
                        t_q.hr  <= '0;
                        t_q.dow <= (t_q.dow >= 3'd7) ? 3'd1 : t_q.dow + 1'b1;
                    end
                end
            end
        end
    end

    assign tod = t_q;

    p_locked_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !sec_en) |=> $stable(t_q));

    p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && sec_en && t_q.sec == 6'd59) |=> (t_q.sec == 6'd0));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tod_t       now,
    input  tod_t       setp,
    input  logic [3:0] en,
    output logic       match
);
    logic [3:0] eq;

    assign eq[0] = (now.sec == setp.sec);
    assign eq[1] = (now.min == setp.min);
    assign eq[2] = (now.hr  == setp.hr);
    assign eq[3] = (now.dow == setp.dow);

    assign match = (en != 4'b0) && ((eq | ~en) == 4'hF);

    p_no_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 4'b0) |-> !match);
endmodule

// File: rtl/rtc_top.sv
module rtc_top
    import rtc_pkg::*;
#(
    parameter int XTAL_DIV = 32768,
    parameter int M50_DIV  = 50,
    parameter int M60_DIV  = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xtal_tick,
    input  logic         mains_tick,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic         irq
);
    logic hold_q, src_q, m60_q, ie_q, flag_q, cmp_q;
    tod_t alm_q, tod;
    logic [3:0] aen_q, wr_field;
    logic wr_ctrl, rd_ctrl, sec_en, match;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign rd_ctrl = bus_sel && !bus_wr && (bus_addr == A_CTRL);

    for (genvar g = 0; g < 4; g++) begin : g_wr
        assign wr_field[g] = bus_sel && bus_wr && (bus_addr == A_SEC + AW'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0; src_q <= 1'b0; m60_q <= 1'b0; ie_q <= 1'b0;
            alm_q  <= '0;   aen_q <= '0;
            cmp_q  <= 1'b0; flag_q <= 1'b0;
        end else begin
            cmp_q <= sec_en || (wr_ctrl && !bus_wdata[0]);
            if (wr_ctrl) begin
                hold_q <= bus_wdata[0];
                src_q  <= bus_wdata[1];
                m60_q  <= bus_wdata[2];
                ie_q   <= bus_wdata[3];
            end
            if (bus_sel && bus_wr) begin
                unique case (bus_addr)
                    A_ASEC:  alm_q.sec <= bus_wdata[5:0];
                    A_AMIN:  alm_q.min <= bus_wdata[5:0];
                    A_AHR:   alm_q.hr  <= bus_wdata[4:0];
                    A_ADOW:  alm_q.dow <= bus_wdata[2:0];
                    A_AEN:   aen_q     <= bus_wdata[3:0];
                    default: ;
                endcase
            end
            if (cmp_q && match) flag_q <= 1'b1;
            else if (rd_ctrl)   flag_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {flag_q, 3'b0, ie_q, m60_q, src_q, hold_q};
            A_SEC:   bus_rdata = {2'b0, tod.sec};
            A_MIN:   bus_rdata = {2'b0, tod.min};
            A_HR:    bus_rdata = {3'b0, tod.hr};
            A_DOW:   bus_rdata = {5'b0, tod.dow};
            A_ASEC:  bus_rdata = {2'b0, alm_q.sec};
            A_AMIN:  bus_rdata = {2'b0, alm_q.min};
            A_AHR:   bus_rdata = {3'b0, alm_q.hr};
            A_ADOW:  bus_rdata = {5'b0, alm_q.dow};
            A_AEN:   bus_rdata = {4'b0, aen_q};
            default: bus_rdata = '0;
        endcase
    end

    assign irq = flag_q && ie_q;

    rtc_prescaler #(.XTAL_DIV(XTAL_DIV), .M50_DIV(M50_DIV), .M60_DIV(M60_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .mains_tick(mains_tick),
        .src_mains(src_q), .mains60(m60_q), .hold(hold_q), .restart(wr_ctrl),
        .sec_en(sec_en)
    );

    rtc_counters u_cnt (
        .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .hold(hold_q),
        .wr_field(wr_field), .wdata(bus_wdata), .tod(tod)
    );

    rtc_alarm_match u_match (
        .clk(clk), .rst_n(rst_n), .now(tod), .setp(alm_q), .en(aen_q), .match(match)
    );

    p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> !sec_en);

    p_tick_compare_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_en |=> cmp_q);

    p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q && match && ie_q && !wr_ctrl) |=> irq);

    p_rd_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !(cmp_q && match)) |=> !flag_q);
endmodule

// File: tb/test_rtc_top.sv
module test_rtc_top;
    import rtc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xtal_tick = 1'b0, mains_tick = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    logic [7:0] cap;
    event rd_ev;

    always #4 clk = ~clk;

    rtc_top #(.XTAL_DIV(4)) i_rtc_top (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .mains_tick(mains_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(rd_ev) begin
        item_t it;
        it = exp_q.pop_front();
        total++;
        if (cap !== it.exp) begin
            bad++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", it.tag, cap, it.exp);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        #3;
        cap = bus_rdata;
        -> rd_ev;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s: actual irq=%0b expected=%0b", tag, irq, e);
        end
    endtask

    task automatic ticks(input bit mains, input int n);
        @(negedge clk);
        if (mains) mains_tick = 1'b1; else xtal_tick = 1'b1;
        repeat (n) @(negedge clk);
        mains_tick = 1'b0; xtal_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_CTRL, 8'h00, "R1 ctrl");
        rd(A_AEN,  8'h00, "R1 enable mask");
        rd(A_SEC,  8'd0,  "R1 sec");
        rd(A_DOW,  8'd1,  "R1 dow");
        chk_irq(1'b0, "R1 irq");
        // R4 locked count write ignored
        wr(A_SEC, 8'd5);
        rd(A_SEC, 8'd0, "R4 locked write");
        // R5 rollover
        wr(A_CTRL, 8'h01);
        wr(A_SEC, 8'd58); wr(A_MIN, 8'd59); wr(A_HR, 8'd23); wr(A_DOW, 8'd7);
        rd(A_SEC, 8'd58, "R4 unlocked write");
        wr(A_CTRL, 8'h00);
        idle(1);
        ticks(0, 8);
        rd(A_SEC, 8'd0, "R5 sec wrap");
        rd(A_MIN, 8'd0, "R5 min wrap");
        rd(A_HR,  8'd0, "R5 hr wrap");
        rd(A_DOW, 8'd1, "R5 dow wrap");
        // alarm set-up
        wr(A_CTRL, 8'h01);
        wr(A_SEC, 8'd30); wr(A_MIN, 8'd20); wr(A_HR, 8'd10); wr(A_DOW, 8'd3);
        wr(A_ASEC, 8'd32); wr(A_AHR, 8'd10); wr(A_AMIN, 8'd45);
        wr(A_AEN, 8'h05);
        rd(A_AMIN, 8'd45, "R6 alarm readback");
        wr(A_CTRL, 8'h08);
        idle(1);
        ticks(0, 4);
        idle(2);
        rd(A_CTRL, 8'h08, "R7 no match at 31");
        ticks(0, 4);
        idle(2);
        chk_irq(1'b1, "R10 irq on match");
        rd(A_CTRL, 8'h88, "R8 flag on tick match");
        rd(A_CTRL, 8'h08, "R11 read clears flag");
        chk_irq(1'b0, "R11 irq cleared");
        // R9 forced compare, R10 irq gated off
        wr(A_CTRL, 8'h00);
        idle(2);
        chk_irq(1'b0, "R10 irq gated");
        rd(A_CTRL, 8'h80, "R9 forced compare");
        // R3 restart splits a second
        ticks(0, 3);
        wr(A_CTRL, 8'h00);
        idle(1);
        ticks(0, 3);
        rd(A_SEC, 8'd32, "R3 restart");
        ticks(0, 1);
        rd(A_SEC, 8'd33, "R2 xtal second");
        rd(A_CTRL, 8'h80, "R9 forced compare on restart");
        // R7 no enables never matches, R6 locked alarm write
        wr(A_AEN, 8'h00);
        wr(A_ASEC, 8'd33);
        rd(A_ASEC, 8'd33, "R6 locked alarm write");
        wr(A_CTRL, 8'h00);
        idle(2);
        rd(A_CTRL, 8'h00, "R7 empty mask");
        wr(A_AEN, 8'h01);
        wr(A_CTRL, 8'h00);
        idle(2);
        rd(A_CTRL, 8'h80, "R9 forced match");
        // R2 mains modes
        wr(A_CTRL, 8'h06);
        idle(1);
        ticks(1, 59);
        rd(A_SEC, 8'd33, "R2 mains60 short");
        ticks(1, 1);
        rd(A_SEC, 8'd34, "R2 mains60 second");
        ticks(0, 10);
        rd(A_SEC, 8'd34, "R2 xtal ignored in mains");
        wr(A_CTRL, 8'h02);
        idle(1);
        ticks(1, 49);
        rd(A_SEC, 8'd34, "R2 mains50 short");
        ticks(1, 1);
        rd(A_SEC, 8'd35, "R2 mains50 second");
        // R3 hold
        wr(A_CTRL, 8'h01);
        idle(1);
        ticks(0, 12);
        rd(A_SEC, 8'd35, "R3 hold");
        idle(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule